// File: doc/BRIEF.md
# Folded Symmetric FIR Filter

This block is an eight-register symmetric FIR filter in fixed point. Each accepted input sample enters a chain of eight sample registers. The output is formed only from the register contents as they stand just before the shift, so the sample being accepted does not contribute to its own result. Because the coefficient set is symmetric, mirrored registers are first added in pairs. Four multipliers then serve all eight taps. The four coefficients are not constants: they arrive on an input bus beside each sample, so a host can change the response from one sample to the next.

Samples and coefficients are 16-bit two's-complement values with 15 fraction bits. The pre-adders widen by one bit, and the products and the two-level adder tree keep full precision. The result is rounded once and clamped back to 16 bits. The same stream also carries the oldest register content, which is the input delayed by eight accepted samples, so the caller can align raw and filtered data.

Both stream edges use valid/ready handshakes. The input is taken on a cycle where `in_valid` and `in_ready` are both high. A result is handed over on a cycle where `out_valid` and `out_ready` are both high. The only back-pressure path is the output register. `in_ready` is low exactly when a held result is waiting and `out_ready` is low. While that lasts the whole block freezes, including the taps. Any number of stall cycles may occur without loss or duplication.

Top module: `mirror_fir`

## Requirements
- R1: `out_delayed` carries, with each result, the sample accepted eight acceptances before the one that produced that result. It carries zero while fewer than eight samples have been accepted since reset.
- R2: With x[n-1] the newest earlier accepted sample, each result is round-and-clamp of c0·(x[n-1]+x[n-8]) + c1·(x[n-2]+x[n-7]) + c2·(x[n-3]+x[n-6]) + c3·(x[n-4]+x[n-5]). The sample x[n] being accepted is not part of its own result.
- R3: Coefficient ck sits at bits [16k+15:16k] of `coef_bus`. So c0 (bits 15:0) weights the pair of first and eighth registers, and c3 (bits 63:48) weights the pair of fourth and fifth registers.
- R4: Rounding adds 16384 to the full-precision Q·30 sum, then shifts arithmetically right by 15. Exact halves therefore round toward plus infinity: +0.5 LSB gives 1 and -0.5 LSB gives 0.
- R5: A rounded value above 32767 is output as 32767. A rounded value below -32768 is output as -32768.
- R6: The coefficients used for a result are those on `coef_bus` in the cycle its sample was accepted. Later changes on the bus do not affect it.
- R7: With `out_ready` held high, a result appears with `out_valid` high on the third rising edge after its sample is accepted. There is exactly one result per accepted sample, in acceptance order.
- R8: `in_ready` equals NOT `out_valid` OR `out_ready`. While `out_valid` is high and `out_ready` is low, `out_valid`, `out_data` and `out_delayed` hold their values.
- R9: A synchronous reset clears all taps and pipeline stages. After reset, `out_valid`, `out_data` and `out_delayed` read zero, and the history seen by later samples is all zeros.
- R10: In cycles where no sample is accepted, neither the taps nor any later result changes, whatever value `in_data` holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Sample offered on `in_data` |
| in_ready | output | 1 | Block can take a sample this cycle |
| in_data | input | 16 | Signed Q1.15 input sample |
| coef_bus | input | 64 | Four signed Q1.15 coefficients, c0 in the low 16 bits |
| out_valid | output | 1 | Result present on `out_data` / `out_delayed` |
| out_ready | input | 1 | Downstream takes the result this cycle |
| out_data | output | 16 | Signed Q1.15 filtered result |
| out_delayed | output | 16 | Sample accepted eight acceptances earlier |

## Verification
A corrupt tap register reaches the ports in two ways. It shows in the very next result, three edges after the next acceptance, because every tap feeds every output. It also travels down the chain and shows on `out_delayed` after at most eight acceptances. A swapped pairing or coefficient lane shows up as a misplaced value within eight results of a single-sample impulse. A mistake in rounding or clamping shows only on results that sit on exact halves or outside the 16-bit range, so those values are driven deliberately. A pipeline that is not frozen during a stall shows as a changed output in the first stalled cycle, or as a skipped or repeated result once the stall ends.

// File: rtl/mfir_pkg.sv
`timescale 1ns/1ps
package mfir_pkg;
  localparam int unsigned SAMPLE_W  = 16;
  localparam int unsigned COEF_W    = 16;
  localparam int unsigned TAP_N     = 8;
  localparam int unsigned FRAC_BITS = 15;

  // headroom of the full-precision sum: pre-add bit, product, tree growth, rounding
  function automatic int unsigned acc_width(int unsigned dw, int unsigned cw,
                                            int unsigned npair);
    return dw + 1 + cw + $clog2(npair) + 1;
  endfunction
endpackage

// File: rtl/mfir_tapline.sv
`timescale 1ns/1ps
module mfir_tapline #(
  parameter int unsigned DW   = 16,
  parameter int unsigned TAPS = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               shift,
  input  logic [DW-1:0]      din,
  output logic [TAPS*DW-1:0] taps
);
  for (genvar i = 0; i < TAPS; i++) begin : g_stage
    logic [DW-1:0] q;
    logic [DW-1:0] feed;
    if (i == 0) begin : g_head
      assign feed = din;
    end else begin : g_body
      assign feed = g_stage[i-1].q;
    end
    always_ff @(posedge clk) begin
      if (rst)        q <= '0;
      else if (shift) q <= feed;
    end
    assign taps[i*DW +: DW] = q;
  end

  // R10
  tap_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !shift |=> $stable(taps));
endmodule

// File: rtl/mfir_pair_mult.sv
`timescale 1ns/1ps
module mfir_pair_mult #(
  parameter int unsigned DW = 16,
  parameter int unsigned CW = 16,
  localparam int unsigned PW = DW + 1,
  localparam int unsigned MW = PW + CW
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 adv,
  input  logic [DW-1:0]        tap_lo,
  input  logic [DW-1:0]        tap_hi,
  input  logic [CW-1:0]        coef,
  output logic signed [MW-1:0] prod
);
  logic signed [PW-1:0] pre_q;
  logic signed [CW-1:0] coef_q;

  // stage A: fold mirrored taps and capture the coefficient with them
  always_ff @(posedge clk) begin
    if (rst) begin
      pre_q  <= '0;
      coef_q <= '0;
    end else if (adv) begin
      pre_q  <= PW'($signed(tap_lo)) + PW'($signed(tap_hi));
      coef_q <= $signed(coef);
    end
  end

  // stage B: full-precision product
  always_ff @(posedge clk) begin
    if (rst)      prod <= '0;
    else if (adv) prod <= MW'(pre_q) * MW'(coef_q);
  end
endmodule

// File: rtl/mfir_sum_sat.sv
`timescale 1ns/1ps
module mfir_sum_sat #(
  parameter int unsigned MW    = 33,
  parameter int unsigned NPAIR = 4,
  parameter int unsigned FRAC  = 15,
  parameter int unsigned OW    = 16,
  parameter int unsigned SW    = 36
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 adv,
  input  logic [NPAIR*MW-1:0]  prods,
  output logic signed [OW-1:0] y
);
  localparam int unsigned NHALF = (NPAIR + 1) / 2;
  localparam logic signed [SW-1:0] HALF = SW'(1) << (FRAC - 1);
  localparam logic signed [SW-1:0] MAXV = (SW'(1) <<< (OW - 1)) - SW'(1);
  localparam logic signed [SW-1:0] MINV = -(SW'(1) <<< (OW - 1));

  // first tree level: neighbouring products
  logic [NHALF-1:0][SW-1:0] part;
  for (genvar j = 0; j < NHALF; j++) begin : g_lvl1
    if (2*j + 1 < NPAIR) begin : g_two
      assign part[j] = SW'($signed(prods[2*j*MW +: MW]))
                     + SW'($signed(prods[(2*j+1)*MW +: MW]));
    end else begin : g_one
      assign part[j] = SW'($signed(prods[2*j*MW +: MW]));
    end
  end

  // second level, then round half up and clamp
  logic signed [SW-1:0] total, rounded, shifted;
  logic signed [OW-1:0] y_d;
  always_comb begin
    total = '0;
    for (int j = 0; j < NHALF; j++) total = total + $signed(part[j]);
    rounded = total + HALF;
    shifted = rounded >>> FRAC;
    if (shifted > MAXV)      y_d = MAXV[OW-1:0];
    else if (shifted < MINV) y_d = MINV[OW-1:0];
    else                     y_d = shifted[OW-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst)      y <= '0;
    else if (adv) y <= y_d;
  end
endmodule

// File: rtl/mirror_fir.sv
`timescale 1ns/1ps
module mirror_fir
  import mfir_pkg::*;
#(
  parameter int unsigned DW   = SAMPLE_W,
  parameter int unsigned CW   = COEF_W,
  parameter int unsigned TAPS = TAP_N,
  parameter int unsigned FRAC = FRAC_BITS,
  localparam int unsigned NP  = TAPS / 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [DW-1:0]    in_data,
  input  logic [NP*CW-1:0] coef_bus,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [DW-1:0]    out_data,
  output logic [DW-1:0]    out_delayed
);
  localparam int unsigned MW = DW + 1 + CW;
  localparam int unsigned SW = acc_width(DW, CW, NP);

  logic adv, fire;
  assign adv      = !out_valid || out_ready;
  assign in_ready = adv;
  assign fire     = in_valid && adv;

  logic [TAPS*DW-1:0] taps;
  mfir_tapline #(.DW(DW), .TAPS(TAPS)) u_taps (
    .clk(clk), .rst(rst), .shift(fire), .din(in_data), .taps(taps)
  );

  // taps k and TAPS-1-k form pair k, weighted by coefficient lane k
  logic [NP*MW-1:0] prods;
  for (genvar k = 0; k < NP; k++) begin : g_pair
    logic signed [MW-1:0] p;
    mfir_pair_mult #(.DW(DW), .CW(CW)) u_pm (
      .clk(clk), .rst(rst), .adv(adv),
      .tap_lo(taps[k*DW +: DW]),
      .tap_hi(taps[(TAPS-1-k)*DW +: DW]),
      .coef(coef_bus[k*CW +: CW]),
      .prod(p)
    );
    assign prods[k*MW +: MW] = p;
  end

  logic signed [DW-1:0] y;
  mfir_sum_sat #(.MW(MW), .NPAIR(NP), .FRAC(FRAC), .OW(DW), .SW(SW)) u_sum (
    .clk(clk), .rst(rst), .adv(adv), .prods(prods), .y(y)
  );
  assign out_data = y;

  // valid flags and oldest tap travel alongside the arithmetic stages
  logic          vld_a, vld_b;
  logic [DW-1:0] dly_a, dly_b;
  always_ff @(posedge clk) begin
    if (rst) begin
      vld_a       <= 1'b0;
      vld_b       <= 1'b0;
      out_valid   <= 1'b0;
      dly_a       <= '0;
      dly_b       <= '0;
      out_delayed <= '0;
    end else if (adv) begin
      vld_a       <= fire;
      vld_b       <= vld_a;
      out_valid   <= vld_b;
      dly_a       <= taps[(TAPS-1)*DW +: DW];
      dly_b       <= dly_a;
      out_delayed <= dly_b;
    end
  end

  // R8
  stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_delayed)));

  // R9
  reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!out_valid && out_data == '0 && out_delayed == '0));

  // R7
  vld_chain_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(out_valid) |-> $past(vld_b));
endmodule

// File: tb/mirror_fir_test.sv
`timescale 1ns/1ps
module mirror_fir_test;
  localparam real PI = 3.14159265358979323846;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid, in_ready, out_valid, out_ready;
  logic [15:0] in_data, out_data, out_delayed;
  logic [63:0] coef_bus;

  always #5 clk = ~clk;

  mirror_fir uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .coef_bus(coef_bus), .out_valid(out_valid),
    .out_ready(out_ready), .out_data(out_data), .out_delayed(out_delayed)
  );

  typedef struct {
    int    y;
    int    d;
    int    cyc;
    bit    tight;
    string tag;
  } exp_t;

  exp_t  q[$];
  int    hist[8];
  int    checks = 0, fails = 0, cyc = 0, ready_mode = 0;
  bit    done = 0;
  string tag = "R9";
  logic [15:0] lfsr = 16'hACE1;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  // downstream readiness patterns
  always @(negedge clk) begin
    lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    case (ready_mode)
      0:       out_ready <= 1'b1;
      1:       out_ready <= lfsr[0] | lfsr[3];
      default: out_ready <= lfsr[0] & lfsr[2];
    endcase
  end

  // reference model and per-cycle comparison
  bit          prev_stall = 0;
  logic [15:0] prev_y, prev_d;
  longint      acc;
  always @(negedge clk) begin
    #2;
    if (rst) begin
      q.delete();
      foreach (hist[i]) hist[i] = 0;
      prev_stall = 0;
    end else begin
      chk(in_ready === (!out_valid || out_ready), "R8", "in_ready",
          in_ready, !out_valid || out_ready);
      if (prev_stall) begin
        chk(out_valid === 1'b1 && out_data === prev_y && out_delayed === prev_d,
            "R8", "held result", $signed(out_data), $signed(prev_y));
      end
      if (out_valid && out_ready) begin
        if (q.size() == 0) begin
          chk(0, "R7", "unexpected result", $signed(out_data), 0);
        end else begin
          exp_t e;
          e = q.pop_front();
          chk($signed(out_data) == e.y, e.tag, "out_data", $signed(out_data), e.y);
          chk($signed(out_delayed) == e.d, "R1", "out_delayed", $signed(out_delayed), e.d);
          if (e.tight && ready_mode == 0)
            chk(cyc - e.cyc == 3, "R7", "latency", cyc - e.cyc, 3);
        end
      end
      if (in_valid && in_ready) begin
        exp_t e;
        acc = 0;
        for (int k = 0; k < 4; k++)
          acc += longint'($signed(coef_bus[k*16 +: 16])) * longint'(hist[k] + hist[7-k]);
        acc = (acc + 16384) >>> 15;
        if (acc > 32767) acc = 32767;
        else if (acc < -32768) acc = -32768;
        e.y = int'(acc); e.d = hist[7]; e.cyc = cyc;
        e.tight = (ready_mode == 0); e.tag = tag;
        q.push_back(e);
        for (int i = 7; i > 0; i--) hist[i] = hist[i-1];
        hist[0] = $signed(in_data);
      end
      prev_stall = out_valid && !out_ready;
      prev_y = out_data;
      prev_d = out_delayed;
    end
  end

  function automatic logic [63:0] pack4(int a, int b, int c, int d);
    return {16'(d), 16'(c), 16'(b), 16'(a)};
  endfunction

  function automatic int q15(real r);
    return int'($floor(r * 32768.0 + 0.5));
  endfunction

  // offer one sample until taken, then idle with junk on the data lines
  task automatic push(int x, int gap);
    in_valid <= 1'b1;
    in_data  <= 16'(x);
    forever begin
      #1;
      if (in_ready) begin
        @(negedge clk);
        break;
      end
      @(negedge clk);
    end
    in_valid <= 1'b0;
    for (int g = 0; g < gap; g++) begin
      in_data <= 16'(cyc * 40503 + g);
      @(negedge clk);
    end
  endtask

  task automatic drain();
    in_valid <= 1'b0;
    ready_mode = 0;
    for (int i = 0; i < 80; i++) begin
      if (q.size() == 0) break;
      @(negedge clk);
    end
    chk(q.size() == 0, "R7", "results outstanding", q.size(), 0);
  endtask

  initial begin
    #2_000_000;
    chk(0, "R7", "watchdog expired", cyc, 0);
    summary();
  end

  real t, xr;
  initial begin
    in_valid = 0; in_data = '0; coef_bus = '0; out_ready = 1;
    repeat (3) @(negedge clk);
    rst <= 1'b0;
    @(negedge clk); #3;
    // R9 reset state
    chk(out_valid === 1'b0, "R9", "out_valid after reset", out_valid, 0);
    chk(out_data === 16'd0, "R9", "out_data after reset", $signed(out_data), 0);
    chk(out_delayed === 16'd0, "R9", "out_delayed after reset", $signed(out_delayed), 0);
    chk(in_ready === 1'b1, "R9", "in_ready after reset", in_ready, 1);
    @(negedge clk);

    // R3 impulse through distinct lanes
    tag = "R3";
    coef_bus <= pack4(100, -300, 700, 1100);
    push(8192, 0);
    for (int i = 0; i < 10; i++) push(0, 0);

    // R2 chirp with the reference coefficients
    tag = "R2";
    coef_bus <= pack4(q15(-0.1339), q15(-0.0838), q15(0.2026), q15(0.4064));
    for (int i = 0; i < 2001; i++) begin
      t  = i * 0.001;
      xr = $cos(2.0 * PI * t * (1.0 + 75.0 * t));
      push(int'($floor(xr * 32767.0 + 0.5)), (i % 7 == 6) ? 1 : 0);
    end

    // R4 exact halves
    tag = "R4";
    coef_bus <= pack4(16384, 0, 0, 0);
    push(1, 0);
    for (int i = 0; i < 8; i++) push(0, 0);
    push(-1, 0);
    for (int i = 0; i < 8; i++) push(0, 0);
    push(3, 0);
    for (int i = 0; i < 8; i++) push(0, 0);

    // R5 clamping in both directions
    tag = "R5";
    coef_bus <= pack4(-32768, -32768, -32768, -32768);
    for (int i = 0; i < 10; i++) push(-32768, 0);
    for (int i = 0; i < 10; i++) push(32767, 0);
    coef_bus <= pack4(32767, 32767, 32767, 32767);
    for (int i = 0; i < 10; i++) push(32767, 0);

    // R6 per-sample coefficients under moderate back-pressure
    tag = "R6";
    ready_mode = 1;
    for (int i = 0; i < 60; i++) begin
      coef_bus <= pack4(i * 1237, 9000 - i * 311, i * i * 17, -i * 523);
      push(i * 2311 - 30000, 0);
    end

    // R8 heavy back-pressure
    tag = "R8";
    ready_mode = 2;
    coef_bus <= pack4(-2000, 5000, -7000, 12000);
    for (int i = 0; i < 40; i++) push(i * 1700 - 20000, 0);

    // R10 idle cycles with junk data
    tag = "R10";
    ready_mode = 0;
    for (int i = 0; i < 30; i++) push(i * 911 - 9000, 3);
    drain();

    // R9 mid-stream reset clears history
    @(negedge clk);
    rst <= 1'b1;
    repeat (2) @(negedge clk);
    rst <= 1'b0;
    @(negedge clk);
    tag = "R9";
    coef_bus <= pack4(3000, -4000, 5000, -6000);
    push(20000, 0);
    for (int i = 0; i < 9; i++) push(0, 0);
    drain();

    summary();
  end
endmodule